// File: doc/BRIEF.md
# Parallel Convolution Multiply-Accumulate Engine

This block turns one complete square window of signed pixels, all presented on a single cycle, into one signed output sample. Every pixel is multiplied by its own stored coefficient in the same clock period. The products and a stored bias then go through a registered adder tree. The fan-in of each tree node is a parameter, so the tree depth, and with it the latency, follows from that choice. A valid strobe travels alongside the data, so the result and its qualifier leave together.

Coefficients and the bias are written before a stream of windows starts and stay fixed while the windows flow. A coefficient is written by tap index, one per cycle. Several copies can sit side by side on the same window bus, one per output feature map, each holding its own coefficients.

Top module: `conv_mac_engine`

## Requirements
- R1: While reset is high, and after it falls until the first window has crossed the pipeline, `res_valid` is 0 and `res_data` is 0. Reset clears all coefficients and the bias to 0.
- R2: For each accepted window, `res_data` equals bias + sum over i of coef[i]·pix[i], in two's complement. Tap i (i = row·KDIM + column, 0..24 for the default 5×5 kernel) occupies bits `win_pix[i*PIX_W +: PIX_W]`. Coefficient index i applies to tap i.
- R3: A window presented with `win_valid` high appears at the output 1 + L cycles later, where L is the number of tree levels needed to reduce 26 terms with the chosen fan-in. For fan-in 2 the latency is 6 cycles; for fan-in 4 (and 3) it is 4 cycles.
- R4: Windows may be presented on consecutive cycles or with gaps. `res_valid` reproduces the input valid pattern exactly, delayed by the latency, and the results keep their input order.
- R5: A write with `coef_we` high and `coef_idx` below 25 stores `coef_val` as the coefficient of that tap. It is used by every window presented from the next cycle on. A write is allowed only while no window is in flight.
- R6: A write with `coef_idx` of 25 to 31 changes no coefficient.
- R7: A write with `bias_we` high stores `bias_val` as the bias. It is used by every window presented from the next cycle on. It is allowed only while no window is in flight.
- R8: The output is PIX_W + WGT_W + 5 bits wide (21 by default). For any pixel, coefficient and bias values the sum is exact, including all pixels −128 times all coefficients −128 plus bias 32767 = 442367.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| win_valid | input | 1 | Window on `win_pix` is to be processed |
| win_pix | input | KDIM·KDIM·PIX_W (200) | Window pixels, signed, tap i at bits i·PIX_W |
| coef_we | input | 1 | Coefficient write strobe |
| coef_idx | input | $clog2(KDIM·KDIM) (5) | Tap index of the coefficient write |
| coef_val | input | WGT_W (8) | Signed coefficient value |
| bias_we | input | 1 | Bias write strobe |
| bias_val | input | BIAS_W (16) | Signed bias value |
| res_valid | output | 1 | `res_data` holds a result |
| res_data | output | PIX_W+WGT_W+5 (21) | Signed sum of products plus bias |

## Verification
Two engines, one with fan-in 2 and one with fan-in 4, share one input stream, so a latency error shows up as a timing mismatch in one of them. Three patterns test the sum itself. Zero coefficients with a bias isolate the bias path. A window with a single nonzero pixel against distinct coefficients exposes any tap that is misplaced or swapped. Pixels and coefficients at full negative and positive scale catch loss of guard bits or of sign extension. Random back-to-back windows and bursts with gaps separate correct ordering and valid alignment from a pipeline that drops, repeats or shifts results. Writes to out-of-range indices, and a rewrite of one coefficient, show whether the coefficient store decodes its index.

// File: rtl/conv_mac_pkg.sv
package conv_mac_pkg;

   // number of registered reduction levels needed to bring n terms down to one
   function automatic int tree_levels(input int n, input int f);
      int c;
      int l;
      c = n;
      l = 0;
      if (f < 2) return 0;
      while (c > 1) begin
         c = (c + f - 1) / f;
         l = l + 1;
      end
      return l;
   endfunction

   // number of partial sums left after lvl levels
   function automatic int level_nodes(input int n, input int f, input int lvl);
      int c;
      c = n;
      for (int i = 0; i < lvl; i++) c = (c + f - 1) / f;
      return c;
   endfunction

endpackage

// File: rtl/conv_coef_bank.sv
module conv_coef_bank #(
   parameter int TAPS   = 25,
   parameter int WGT_W  = 8,
   parameter int BIAS_W = 16,
   parameter int IDX_W  = 5
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     coef_we,
   input  logic [IDX_W-1:0]         coef_idx,
   input  logic [WGT_W-1:0]         coef_val,
   input  logic                     bias_we,
   input  logic [BIAS_W-1:0]        bias_val,
   output logic [TAPS*WGT_W-1:0]    coef_flat,
   output logic [BIAS_W-1:0]        bias_q
);

   localparam logic [IDX_W:0] TAPS_L = (IDX_W+1)'(TAPS);

   logic [WGT_W-1:0] coef_q [TAPS];
   logic             idx_ok;

   assign idx_ok = ({1'b0, coef_idx} < TAPS_L);

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < TAPS; i++) coef_q[i] <= '0;
         bias_q <= '0;
      end else begin
         if (coef_we && idx_ok) coef_q[coef_idx] <= coef_val;
         if (bias_we) bias_q <= bias_val;
      end
   end

   for (genvar i = 0; i < TAPS; i++) begin : g_flat
      assign coef_flat[i*WGT_W +: WGT_W] = coef_q[i];
   end

endmodule

// File: rtl/conv_mul_stage.sv
module conv_mul_stage #(
   parameter int TAPS   = 25,
   parameter int PIX_W  = 8,
   parameter int WGT_W  = 8,
   parameter int BIAS_W = 16,
   parameter int ACC_W  = 21
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic [TAPS*PIX_W-1:0]       pix_flat,
   input  logic [TAPS*WGT_W-1:0]       coef_flat,
   input  logic [BIAS_W-1:0]           bias_q,
   output logic [(TAPS+1)*ACC_W-1:0]   leaf_flat
);

   localparam int PROD_W = PIX_W + WGT_W;

   for (genvar i = 0; i < TAPS; i++) begin : g_mul
      logic signed [PROD_W-1:0] prod;
      assign prod = $signed(pix_flat[i*PIX_W +: PIX_W]) * $signed(coef_flat[i*WGT_W +: WGT_W]);
      always_ff @(posedge clk) begin
         if (rst) leaf_flat[i*ACC_W +: ACC_W] <= '0;
         else     leaf_flat[i*ACC_W +: ACC_W] <= {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
      end
   end

   // bias enters the tree as one extra leaf, aligned with the products
   always_ff @(posedge clk) begin
      if (rst) leaf_flat[TAPS*ACC_W +: ACC_W] <= '0;
      else     leaf_flat[TAPS*ACC_W +: ACC_W] <= {{(ACC_W-BIAS_W){bias_q[BIAS_W-1]}}, bias_q};
   end

endmodule

// File: rtl/conv_add_tree.sv
module conv_add_tree
   import conv_mac_pkg::*;
#(
   parameter int NLEAF = 26,
   parameter int FANIN = 2,
   parameter int ACC_W = 21
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [NLEAF*ACC_W-1:0]   leaf_flat,
   output logic [ACC_W-1:0]         sum_q
);

   localparam int LEVELS = tree_levels(NLEAF, FANIN);

   for (genvar l = 1; l <= LEVELS; l++) begin : g_lvl
      localparam int PCNT = level_nodes(NLEAF, FANIN, l-1);
      localparam int CNT  = level_nodes(NLEAF, FANIN, l);

      logic [PCNT*ACC_W-1:0] prv;
      logic [CNT*ACC_W-1:0]  nxt;
      logic [CNT*ACC_W-1:0]  q;

      if (l == 1) begin : g_src_leaf
         assign prv = leaf_flat;
      end else begin : g_src_lvl
         assign prv = g_lvl[l-1].q;
      end

      always_comb begin
         nxt = '0;
         for (int j = 0; j < CNT; j++) begin
            logic signed [ACC_W-1:0] acc;
            acc = '0;
            for (int k = 0; k < FANIN; k++) begin
               if (j*FANIN + k < PCNT) acc = acc + $signed(prv[(j*FANIN+k)*ACC_W +: ACC_W]);
            end
            nxt[j*ACC_W +: ACC_W] = acc;
         end
      end

      always_ff @(posedge clk) begin
         if (rst) q <= '0;
         else     q <= nxt;
      end
   end

   assign sum_q = g_lvl[LEVELS].q;

endmodule

// File: rtl/conv_vld_pipe.sv
module conv_vld_pipe #(
   parameter int DEPTH = 6
) (
   input  logic clk,
   input  logic rst,
   input  logic in_v,
   output logic out_v,
   output logic busy
);

   logic [DEPTH-1:0] sr;

   always_ff @(posedge clk) begin
      if (rst) sr <= '0;
      else     sr <= {sr[DEPTH-2:0], in_v};
   end

   assign out_v = sr[DEPTH-1];
   assign busy  = |sr;

endmodule

// File: rtl/conv_mac_engine.sv
module conv_mac_engine
   import conv_mac_pkg::*;
#(
   parameter int KDIM   = 5,
   parameter int PIX_W  = 8,
   parameter int WGT_W  = 8,
   parameter int BIAS_W = 16,
   parameter int FANIN  = 2,
   localparam int TAPS   = KDIM * KDIM,
   localparam int IDX_W  = $clog2(TAPS),
   localparam int ACC_W  = PIX_W + WGT_W + $clog2(TAPS + 1)
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    win_valid,
   input  logic [TAPS*PIX_W-1:0]   win_pix,
   input  logic                    coef_we,
   input  logic [IDX_W-1:0]        coef_idx,
   input  logic [WGT_W-1:0]        coef_val,
   input  logic                    bias_we,
   input  logic [BIAS_W-1:0]       bias_val,
   output logic                    res_valid,
   output logic [ACC_W-1:0]        res_data
);

   localparam int NLEAF = TAPS + 1;
   localparam int LAT   = 1 + tree_levels(NLEAF, FANIN);

   if (FANIN < 2) begin : g_bad_fanin
      $error("conv_mac_engine: FANIN must be at least 2");
   end
   if (KDIM < 2) begin : g_bad_kdim
      $error("conv_mac_engine: KDIM must be at least 2");
   end
   if (BIAS_W > PIX_W + WGT_W) begin : g_bad_bias
      $error("conv_mac_engine: BIAS_W must not exceed the product width");
   end
   if (LAT > 200) begin : g_bad_lat
      $error("conv_mac_engine: pipeline too deep for the checker counters");
   end

   logic [TAPS*WGT_W-1:0]   coef_flat;
   logic [BIAS_W-1:0]       bias_q;
   logic [NLEAF*ACC_W-1:0]  leaf_flat;
   logic                    busy;

   conv_coef_bank #(.TAPS(TAPS), .WGT_W(WGT_W), .BIAS_W(BIAS_W), .IDX_W(IDX_W)) u_bank (
      .clk(clk), .rst(rst),
      .coef_we(coef_we), .coef_idx(coef_idx), .coef_val(coef_val),
      .bias_we(bias_we), .bias_val(bias_val),
      .coef_flat(coef_flat), .bias_q(bias_q)
   );

   conv_mul_stage #(.TAPS(TAPS), .PIX_W(PIX_W), .WGT_W(WGT_W), .BIAS_W(BIAS_W), .ACC_W(ACC_W)) u_mul (
      .clk(clk), .rst(rst),
      .pix_flat(win_pix), .coef_flat(coef_flat), .bias_q(bias_q),
      .leaf_flat(leaf_flat)
   );

   conv_add_tree #(.NLEAF(NLEAF), .FANIN(FANIN), .ACC_W(ACC_W)) u_tree (
      .clk(clk), .rst(rst),
      .leaf_flat(leaf_flat), .sum_q(res_data)
   );

   conv_vld_pipe #(.DEPTH(LAT)) u_vld (
      .clk(clk), .rst(rst),
      .in_v(win_valid), .out_v(res_valid), .busy(busy)
   );

   // checker state: windows in flight and cycles since the last window
   logic [7:0] inflight;
   logic [7:0] idle_cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         inflight <= '0;
         idle_cnt <= '0;
      end else begin
         inflight <= inflight + {7'd0, win_valid} - {7'd0, res_valid};
         if (win_valid)                idle_cnt <= '0;
         else if (idle_cnt < 8'(LAT))  idle_cnt <= idle_cnt + 8'd1;
      end
   end

   // R4
   valid_origin_chk: assert property (@(posedge clk) disable iff (rst)
      res_valid |-> (inflight != 8'd0));

   // R3
   idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (idle_cnt == 8'(LAT)) |-> !res_valid);

   // R5
   load_guard_chk: assert property (@(posedge clk) disable iff (rst)
      coef_we |-> !(win_valid || busy));

   // R7
   bias_guard_chk: assert property (@(posedge clk) disable iff (rst)
      bias_we |-> !(win_valid || busy));

endmodule

// File: tb/conv_mac_engine_tb_top.sv
`timescale 1ns/1ps
module conv_mac_engine_tb_top;

   localparam int NT = 25;

   typedef struct {
      bit      v;
      longint  s;
      string   tag;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         win_valid = 1'b0;
   logic [199:0] win_pix = '0;
   logic         coef_we = 1'b0;
   logic [4:0]   coef_idx = '0;
   logic [7:0]   coef_val = '0;
   logic         bias_we = 1'b0;
   logic [15:0]  bias_val = '0;
   logic         vld2, vld4;
   logic [20:0]  res2, res4;

   always #4 clk = ~clk;

   conv_mac_engine #(.FANIN(2)) dut_i (
      .clk(clk), .rst(rst), .win_valid(win_valid), .win_pix(win_pix),
      .coef_we(coef_we), .coef_idx(coef_idx), .coef_val(coef_val),
      .bias_we(bias_we), .bias_val(bias_val),
      .res_valid(vld2), .res_data(res2)
   );

   conv_mac_engine #(.FANIN(4)) dut4_i (
      .clk(clk), .rst(rst), .win_valid(win_valid), .win_pix(win_pix),
      .coef_we(coef_we), .coef_idx(coef_idx), .coef_val(coef_val),
      .bias_we(bias_we), .bias_val(bias_val),
      .res_valid(vld4), .res_data(res4)
   );

   int     n_chk = 0;
   int     n_fail = 0;
   int     w_m [NT];
   int     bias_m = 0;
   int     pix [NT];
   bit     ld_en = 0;
   int     ld_idx = 0;
   int     ld_val = 0;
   bit     b_we = 0;
   int     b_val = 0;
   exp_t   q2 [$];
   exp_t   q4 [$];

   task automatic chk(input exp_t e, input logic av, input logic [20:0] ad, input string nm);
      longint act;
      act = longint'($signed(ad));
      n_chk++;
      if (av !== e.v) begin
         n_fail++;
         $display("FAIL %s %s out_valid=%0b expected=%0b (R3 latency, R4 ordering)", e.tag, nm, av, e.v);
      end
      if (e.v || e.tag == "R1") begin
         n_chk++;
         if (act != e.s) begin
            n_fail++;
            $display("FAIL %s %s result=%0d expected=%0d", e.tag, nm, act, e.s);
         end
      end
   endtask

   task automatic step(input bit v, input string tag);
      exp_t e;
      longint sum;
      @(negedge clk);
      chk(q2.pop_front(), vld2, res2, "fanin2");
      chk(q4.pop_front(), vld4, res4, "fanin4");
      win_valid = v;
      for (int i = 0; i < NT; i++) win_pix[i*8 +: 8] = 8'(pix[i]);
      coef_we  = ld_en;
      coef_idx = 5'(ld_idx);
      coef_val = 8'(ld_val);
      bias_we  = b_we;
      bias_val = 16'(b_val);
      sum = bias_m;
      for (int i = 0; i < NT; i++) sum += longint'(w_m[i]) * longint'(pix[i]);
      e.v = v; e.s = sum; e.tag = tag;
      q2.push_back(e);
      q4.push_back(e);
      if (ld_en && ld_idx < NT) w_m[ld_idx] = ld_val;
      if (b_we) bias_m = b_val;
      ld_en = 0;
      b_we = 0;
   endtask

   task automatic flush(input int n);
      for (int i = 0; i < n; i++) step(0, "R4");
   endtask

   task automatic load_w(input int idx, input int val, input string tag);
      ld_en = 1; ld_idx = idx; ld_val = val;
      step(0, tag);
   endtask

   task automatic load_b(input int val, input string tag);
      b_we = 1; b_val = val;
      step(0, tag);
   endtask

   task automatic rand_pix();
      for (int i = 0; i < NT; i++) pix[i] = int'($urandom_range(0, 255)) - 128;
   endtask

   task automatic fill_pix(input int val);
      for (int i = 0; i < NT; i++) pix[i] = val;
   endtask

   initial begin
      #(200000 * 8);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      exp_t z;
      for (int i = 0; i < NT; i++) begin w_m[i] = 0; pix[i] = 0; end
      // R1: outputs quiet during reset
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         n_chk++;
         if (vld2 !== 1'b0 || vld4 !== 1'b0 || res2 !== '0 || res4 !== '0) begin
            n_fail++;
            $display("FAIL R1 in reset valid=%0b/%0b result=%0d/%0d expected=0", vld2, vld4, res2, res4);
         end
      end
      @(negedge clk);
      rst = 1'b0;
      z.v = 0; z.s = 0; z.tag = "R1";
      for (int i = 0; i < 6; i++) q2.push_back(z);
      for (int i = 0; i < 4; i++) q4.push_back(z);
      flush(2);

      // R7: bias only, coefficients still zero after reset
      load_b(1234, "R7");
      for (int i = 0; i < 3; i++) begin rand_pix(); step(1, "R7"); end
      flush(8);

      // R5 / R2: distinct coefficients, single nonzero pixel locates each tap
      for (int i = 0; i < NT; i++) load_w(i, i + 1, "R5");
      foreach (pix[k]) begin
         if (k == 0 || k == 4 || k == 12 || k == 20 || k == 24) begin
            fill_pix(0);
            pix[k] = 3;
            step(1, "R2");
         end
      end
      for (int i = 0; i < 4; i++) begin rand_pix(); step(1, "R2"); end
      flush(8);

      // R6: out-of-range indices must not disturb any coefficient
      for (int i = 25; i < 32; i++) load_w(i, 77, "R6");
      fill_pix(1);
      step(1, "R6");
      flush(8);

      // R5: rewrite one coefficient
      load_w(7, -50, "R5");
      rand_pix();
      step(1, "R5");
      flush(8);

      // R4: random coefficients, back-to-back then gapped windows
      for (int i = 0; i < NT; i++) load_w(i, int'($urandom_range(0, 255)) - 128, "R5");
      load_b(int'($urandom_range(0, 65535)) - 32768, "R7");
      for (int i = 0; i < 40; i++) begin rand_pix(); step(1, "R4"); end
      for (int i = 0; i < 60; i++) begin rand_pix(); step(bit'($urandom_range(0, 1)), "R4"); end
      flush(8);

      // R8: full-scale sums
      for (int i = 0; i < NT; i++) load_w(i, -128, "R8");
      load_b(32767, "R8");
      fill_pix(-128);
      step(1, "R8");
      fill_pix(127);
      step(1, "R8");
      flush(8);
      for (int i = 0; i < NT; i++) load_w(i, 127, "R8");
      load_b(-32768, "R8");
      fill_pix(-128);
      step(1, "R8");
      fill_pix(127);
      step(1, "R8");
      flush(8);

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule